// File: doc/BRIEF.md
# PWM Generator with Fault and Current-Limit Overrides

A single-channel pulse-width modulator that drives a high-side pin and a low-side pin from one primary period counter. The period and duty values enter as plain inputs; everything else that shapes the waveform sits in one 16-bit control register behind a byte-enabled write port. That register holds the output arrangement, the override policy, the input polarities and the levels that overridden pins take. The output arrangement is complementary, redundant or push-pull.

Two protection inputs, a fault and a current limit, feed an override stage between the waveform generator and the pins. Each input has its own tracker. The tracker either follows the input cycle by cycle and releases on the primary period boundary, or latches on a single polarity-selected edge until a clear strobe arrives. In shared routing, either input forces both pins. In independent routing, the current limit acts only on the high-side pin and the fault acts only on the low-side pin. Both pins are registered. The control register can be read back whole.

Top module: `pwm_fault_gen`

## Requirements
- R1: With the output-arrangement field cfg[1:0] = 00 (code 11 behaves the same), pwm_lo is the inverse of pwm_hi. Both pins are low while rst_n is low.
- R2: With cfg[1:0] = 01, pwm_lo carries the same waveform as pwm_hi.
- R3: With cfg[1:0] = 10, the pulse appears on pwm_hi in one period and on pwm_lo in the next, alternating. The two pins are never high together.
- R4: A period value P (P >= 1) gives periods of P clock cycles. The high-side pulse lasts for the first min(D, P) cycles of each period. A duty D of 0 gives a constant inactive pulse, and D >= P gives a constant active pulse.
- R5: With cfg[5] = 0, new period and duty values are held in shadows and used only from the next period boundary. With cfg[5] = 1 they are used from the next clock cycle.
- R6: With cfg[4] = 0, an overriding fault or current limit forces both pins. pwm_hi takes the level in cfg[8] and pwm_lo takes the level in cfg[9], from the first clock edge after the input is sampled active.
- R7: With cfg[4] = 1, only the current limit overrides pwm_hi and only the fault overrides pwm_lo.
- R8: With the override-policy field cfg[3:2] = 01 (cycle-by-cycle), an override lasts while the input is active and until the end of the primary period in which it went inactive. The pin resumes normal output on the first cycle of the next period. Only the primary period counter releases the override.
- R9: With cfg[3:2] = 00 or 10 (latched), an input sets its latch only on the edge selected by its polarity bit: cfg[6] for the fault and cfg[7] for the current limit, where 1 means active-high (rising edge) and 0 means active-low (falling edge). The opposite edge, or a steady active level with no edge, sets nothing.
- R10: A latched override is released by a flt_clear pulse only while its input is inactive. A clear while the input is active has no effect.
- R11: With cfg[3:2] = 11, both protection inputs are ignored.
- R12: cfg_q shows the control register, which resets to 16'h00CC. A write with cfg_wr_en updates only the bytes whose cfg_wr_be bit is set (bit 0 covers [7:0], bit 1 covers [15:8]), and the new value is visible one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr_en | input | 1 | Control-register write strobe |
| cfg_wr_be | input | 2 | Byte enables for the write |
| cfg_wr_data | input | 16 | Write data |
| cfg_q | output | 16 | Current control-register value |
| period | input | CNT_W | Period length in cycles |
| duty | input | CNT_W | High-side pulse length in cycles |
| fault_in | input | 1 | Fault protection input |
| clim_in | input | 1 | Current-limit protection input |
| flt_clear | input | 1 | Release strobe for latched overrides |
| pwm_hi | output | 1 | High-side output pin |
| pwm_lo | output | 1 | Low-side output pin |

## Verification
Both pins are registered, so any change at the inputs or in the configuration appears at the pins on the first clock edge after it is sampled. The bench drives on the falling edge and reads at the following falling edge. Waveform shape is judged by counting high samples over windows of exactly one or two periods, so the count does not depend on the window's phase. The timing checks for period boundaries, shadow updates and cycle-by-cycle release first lock onto an observed rising edge of pwm_hi, which is sample zero of a period. They then check the samples whose index the requirements fix: the current period's duty stays in effect through its eighth sample, and the pin resumes one cycle after the boundary that follows the release.

// File: rtl/pwm_fault_pkg.sv
// Shared types for the PWM generator: output arrangement codes,
// override policy codes and the control-register layout.
// Assumes a 16-bit control register; the field positions are
// part of the external contract.
package pwm_fault_pkg;

    typedef enum logic [1:0] {
        OUT_COMP = 2'b00,
        OUT_RED  = 2'b01,
        OUT_PP   = 2'b10,
        OUT_ALT  = 2'b11
    } out_mode_e;

    typedef enum logic [1:0] {
        FLT_LATCH = 2'b00,
        FLT_CBC   = 2'b01,
        FLT_LATB  = 2'b10,
        FLT_OFF   = 2'b11
    } flt_mode_e;

    typedef struct packed {
        logic [5:0] spare;
        logic       lvl_lo;
        logic       lvl_hi;
        logic       cl_pol;
        logic       flt_pol;
        logic       imm_upd;
        logic       indep;
        flt_mode_e  fmode;
        out_mode_e  omode;
    } cfg_t;

    localparam int CFG_W = $bits(cfg_t);
    localparam logic [CFG_W-1:0] CFG_RESET = 16'h00CC;

endpackage

// File: rtl/pwm_cfg_reg.sv
// Byte-enabled control register. Each byte lane is written only when
// its enable is set together with the write strobe.
// Assumes DATA_W is a multiple of 8.
module pwm_cfg_reg #(
    parameter int DATA_W = 16,
    parameter logic [DATA_W-1:0] RESET_VAL = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W/8-1:0] wr_be,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] q
);
    localparam int NBYTES = DATA_W / 8;

    for (genvar b = 0; b < NBYTES; b++) begin : g_lane
        // Purpose: hold one byte lane, load it on an enabled write.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                q[b*8 +: 8] <= RESET_VAL[b*8 +: 8];
            end else if (wr_en && wr_be[b]) begin
                q[b*8 +: 8] <= wr_data[b*8 +: 8];
            end
        end
    end
endmodule

// File: rtl/pwm_timebase.sv
// Primary time base: a counter that runs 0..P-1, the active period and
// duty registers (loaded at the boundary, or every cycle in immediate
// mode), the raw pulse compare and the alternating-period phase bit.
// Assumes a period of 0 is treated as a one-cycle period.
module pwm_timebase #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] period,
    input  logic [CNT_W-1:0] duty,
    input  logic             imm_upd,
    output logic [CNT_W-1:0] per_act,
    output logic [CNT_W-1:0] duty_act,
    output logic             last,
    output logic             raw,
    output logic             phase
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic [CNT_W-1:0] cnt;

    // Purpose: flag the final cycle of the current period.
    always_comb begin
        last = (per_act == '0) || (cnt >= (per_act - ONE));
    end

    // Purpose: compare; duty of 0 never fires, duty >= period always fires.
    always_comb begin
        raw = (cnt < duty_act);
    end

    // Purpose: advance the counter and wrap it at the boundary.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (last) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + ONE;
        end
    end

    // Purpose: load the active period and duty from their shadows.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            per_act  <= '0;
            duty_act <= '0;
        end else if (imm_upd || last) begin
            per_act  <= period;
            duty_act <= duty;
        end
    end

    // Purpose: toggle the push-pull phase once per period.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= 1'b0;
        end else if (last) begin
            phase <= ~phase;
        end
    end
endmodule

// File: rtl/pwm_out_shaper.sv
// Maps the raw pulse onto the two pins according to the output
// arrangement. Purely combinational; code 11 acts as complementary.
module pwm_out_shaper
    import pwm_fault_pkg::*;
(
    input  out_mode_e omode,
    input  logic      raw,
    input  logic      phase,
    output logic      gen_hi,
    output logic      gen_lo
);
    // Purpose: select the pin waveforms for the chosen arrangement.
    always_comb begin
        case (omode)
            OUT_RED: begin
                gen_hi = raw;
                gen_lo = raw;
            end
            OUT_PP: begin
                gen_hi = raw & ~phase;
                gen_lo = raw & phase;
            end
            default: begin
                gen_hi = raw;
                gen_lo = ~raw;
            end
        endcase
    end
endmodule

// File: rtl/pwm_ovr_track.sv
// Tracks one protection input. Cycle-by-cycle policy: active level sets
// a hold flag released only by the primary period boundary. Latched
// policy: only the polarity-selected edge sets the flag, and a clear
// while the input is inactive releases it. The override output combines
// the flag with the live trigger so the first edge already forces the pin.
// Assumes the input is already synchronous to clk.
module pwm_ovr_track
    import pwm_fault_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      src_in,
    input  logic      pol,
    input  flt_mode_e fmode,
    input  logic      clear,
    input  logic      last,
    output logic      st,
    output logic      ov
);
    logic src_d;
    logic active;
    logic sel_edge;

    // Purpose: decode the active level and the selected edge.
    always_comb begin
        active   = (src_in == pol);
        sel_edge = active && (src_d != pol);
    end

    // Purpose: remember the previous input sample for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            src_d <= 1'b0;
        end else begin
            src_d <= src_in;
        end
    end

    // Purpose: update the hold flag according to the override policy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st <= 1'b0;
        end else begin
            case (fmode)
                FLT_OFF: st <= 1'b0;
                FLT_CBC: begin
                    if (last) begin
                        st <= 1'b0;
                    end else if (active) begin
                        st <= 1'b1;
                    end
                end
                default: begin
                    if (sel_edge) begin
                        st <= 1'b1;
                    end else if (clear && !active) begin
                        st <= 1'b0;
                    end
                end
            endcase
        end
    end

    // Purpose: form the override request seen by the routing stage.
    always_comb begin
        case (fmode)
            FLT_OFF: ov = 1'b0;
            FLT_CBC: ov = st | active;
            default: ov = st | sel_edge;
        endcase
    end
endmodule

// File: rtl/pwm_fault_gen.sv
// Top of the single-channel PWM with fault and current-limit overrides.
// Holds the control register, the primary time base, the output shaper,
// one tracker per protection input (index 0 fault, index 1 current
// limit), the routing between them and the registered pins.
// Assumes protection inputs are synchronous to clk.
module pwm_fault_gen
    import pwm_fault_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_wr_en,
    input  logic [1:0]       cfg_wr_be,
    input  logic [15:0]      cfg_wr_data,
    output logic [15:0]      cfg_q,
    input  logic [CNT_W-1:0] period,
    input  logic [CNT_W-1:0] duty,
    input  logic             fault_in,
    input  logic             clim_in,
    input  logic             flt_clear,
    output logic             pwm_hi,
    output logic             pwm_lo
);
    localparam int NSRC = 2;

    cfg_t             cfg_s;
    logic [CNT_W-1:0] per_act;
    logic [CNT_W-1:0] duty_act;
    logic             last;
    logic             raw;
    logic             phase;
    logic             gen_hi;
    logic             gen_lo;
    logic [NSRC-1:0]  src_vec;
    logic [NSRC-1:0]  pol_vec;
    logic [NSRC-1:0]  st_vec;
    logic [NSRC-1:0]  ov_vec;
    logic             hi_ov;
    logic             lo_ov;

    pwm_cfg_reg #(
        .DATA_W   (CFG_W),
        .RESET_VAL(CFG_RESET)
    ) u_cfg (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (cfg_wr_en),
        .wr_be  (cfg_wr_be),
        .wr_data(cfg_wr_data),
        .q      (cfg_q)
    );

    assign cfg_s = cfg_t'(cfg_q);

    pwm_timebase #(
        .CNT_W(CNT_W)
    ) u_tb (
        .clk     (clk),
        .rst_n   (rst_n),
        .period  (period),
        .duty    (duty),
        .imm_upd (cfg_s.imm_upd),
        .per_act (per_act),
        .duty_act(duty_act),
        .last    (last),
        .raw     (raw),
        .phase   (phase)
    );

    pwm_out_shaper u_shape (
        .omode (cfg_s.omode),
        .raw   (raw),
        .phase (phase),
        .gen_hi(gen_hi),
        .gen_lo(gen_lo)
    );

    assign src_vec = {clim_in, fault_in};
    assign pol_vec = {cfg_s.cl_pol, cfg_s.flt_pol};

    for (genvar s = 0; s < NSRC; s++) begin : g_trk
        pwm_ovr_track u_trk (
            .clk   (clk),
            .rst_n (rst_n),
            .src_in(src_vec[s]),
            .pol   (pol_vec[s]),
            .fmode (cfg_s.fmode),
            .clear (flt_clear),
            .last  (last),
            .st    (st_vec[s]),
            .ov    (ov_vec[s])
        );
    end

    // Purpose: route the two override requests onto the two pins.
    always_comb begin
        if (cfg_s.indep) begin
            hi_ov = ov_vec[1];
            lo_ov = ov_vec[0];
        end else begin
            hi_ov = |ov_vec;
            lo_ov = |ov_vec;
        end
    end

    // Purpose: register the pins, taking the override level when forced.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pwm_hi <= 1'b0;
            pwm_lo <= 1'b0;
        end else begin
            pwm_hi <= hi_ov ? cfg_s.lvl_hi : gen_hi;
            pwm_lo <= lo_ov ? cfg_s.lvl_lo : gen_lo;
        end
    end
endmodule

// File: rtl/pwm_fault_gen_chk.sv
// Property checker for pwm_fault_gen, attached by bind below. Observes
// the configuration, the pins, the time-base registers and the
// tracker hold flags.
module pwm_fault_gen_chk
    import pwm_fault_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input cfg_t             cfg,
    input logic             cfg_wr_en,
    input logic [1:0]       cfg_wr_be,
    input logic             fault_in,
    input logic             pwm_hi,
    input logic             pwm_lo,
    input logic             hi_ov,
    input logic             lo_ov,
    input logic             last,
    input logic [CNT_W-1:0] per_act,
    input logic [CNT_W-1:0] duty_act,
    input logic [1:0]       st_vec
);
    // R1: complementary pins are opposite when not forced
    a_r1_comp_inverse: assert property (@(posedge clk) disable iff (!rst_n)
        ((cfg.omode == OUT_COMP || cfg.omode == OUT_ALT) && !hi_ov && !lo_ov)
        |=> (pwm_lo != pwm_hi));

    // R2: redundant pins match when not forced
    a_r2_red_equal: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg.omode == OUT_RED && !hi_ov && !lo_ov) |=> (pwm_lo == pwm_hi));

    // R3: push-pull pins never high together
    a_r3_pp_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg.omode == OUT_PP && !hi_ov && !lo_ov) |=> !(pwm_hi && pwm_lo));

    // R4: zero duty keeps the high side inactive
    a_r4_zero_duty: assert property (@(posedge clk) disable iff (!rst_n)
        (duty_act == '0 && !hi_ov) |=> !pwm_hi);

    // R5: shadows hold away from the boundary in shadowed mode
    a_r5_shadow_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg.imm_upd && !last) |=> ($stable(duty_act) && $stable(per_act)));

    // R6: forced high side takes its configured level
    a_r6_hi_level: assert property (@(posedge clk) disable iff (!rst_n)
        hi_ov |=> (pwm_hi == $past(cfg.lvl_hi)));

    // R6: forced low side takes its configured level
    a_r6_lo_level: assert property (@(posedge clk) disable iff (!rst_n)
        lo_ov |=> (pwm_lo == $past(cfg.lvl_lo)));

    // R8: the primary boundary releases cycle-by-cycle hold flags
    a_r8_cbc_release: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg.fmode == FLT_CBC && last) |=> (st_vec == 2'b00));

    // R10: a latched fault stays set while its input is active
    a_r10_hold_active: assert property (@(posedge clk) disable iff (!rst_n)
        ((cfg.fmode == FLT_LATCH || cfg.fmode == FLT_LATB) && st_vec[0]
         && (fault_in == cfg.flt_pol)) |=> st_vec[0]);

    // R11: disabled policy clears both hold flags
    a_r11_off_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg.fmode == FLT_OFF) |=> (st_vec == 2'b00));

    // R12: an unselected upper byte keeps its value
    a_r12_keep_upper: assert property (@(posedge clk) disable iff (!rst_n)
        !(cfg_wr_en && cfg_wr_be[1]) |=> (cfg[15:8] == $past(cfg[15:8])));

    // R12: an unselected lower byte keeps its value
    a_r12_keep_lower: assert property (@(posedge clk) disable iff (!rst_n)
        !(cfg_wr_en && cfg_wr_be[0]) |=> (cfg[7:0] == $past(cfg[7:0])));
endmodule

bind pwm_fault_gen pwm_fault_gen_chk #(.CNT_W(CNT_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg      (cfg_s),
    .cfg_wr_en(cfg_wr_en),
    .cfg_wr_be(cfg_wr_be),
    .fault_in (fault_in),
    .pwm_hi   (pwm_hi),
    .pwm_lo   (pwm_lo),
    .hi_ov    (hi_ov),
    .lo_ov    (lo_ov),
    .last     (last),
    .per_act  (per_act),
    .duty_act (duty_act),
    .st_vec   (st_vec)
);

// File: tb/pwm_fault_gen_bench.sv
// Directed bench: one task per scenario, each checking its own results.
module pwm_fault_gen_bench;
    localparam int CNT_W = 16;
    localparam int WATCHDOG = 20000;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             cfg_wr_en = 1'b0;
    logic [1:0]       cfg_wr_be = 2'b00;
    logic [15:0]      cfg_wr_data = 16'h0000;
    logic [15:0]      cfg_q;
    logic [CNT_W-1:0] period = 16'd8;
    logic [CNT_W-1:0] duty = 16'd3;
    logic             fault_in = 1'b0;
    logic             clim_in = 1'b0;
    logic             flt_clear = 1'b0;
    logic             pwm_hi;
    logic             pwm_lo;

    int  n_checks = 0;
    int  n_fail = 0;
    bit  finished = 1'b0;

    always #5 clk = ~clk;

    pwm_fault_gen #(.CNT_W(CNT_W)) u_pwm_fault_gen (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_wr_en  (cfg_wr_en),
        .cfg_wr_be  (cfg_wr_be),
        .cfg_wr_data(cfg_wr_data),
        .cfg_q      (cfg_q),
        .period     (period),
        .duty       (duty),
        .fault_in   (fault_in),
        .clim_in    (clim_in),
        .flt_clear  (flt_clear),
        .pwm_hi     (pwm_hi),
        .pwm_lo     (pwm_lo)
    );

    function automatic logic [15:0] mk_cfg(input logic [1:0] om, input logic [1:0] fm,
                                           input logic ind, input logic imm,
                                           input logic fp, input logic cp,
                                           input logic lh, input logic ll);
        return {6'b0, ll, lh, cp, fp, imm, ind, fm, om};
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr_cfg(input logic [1:0] be, input logic [15:0] data);
        cfg_wr_en = 1'b1;
        cfg_wr_be = be;
        cfg_wr_data = data;
        @(negedge clk);
        cfg_wr_en = 1'b0;
        cfg_wr_be = 2'b00;
    endtask

    task automatic pulse_clear();
        flt_clear = 1'b1;
        @(negedge clk);
        flt_clear = 1'b0;
    endtask

    // Samples n consecutive cycles and tallies the pin patterns.
    task automatic window(input int n, output int hi_c, output int lo_c,
                          output int both0, output int both1, output int eq);
        hi_c = 0; lo_c = 0; both0 = 0; both1 = 0; eq = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (pwm_hi) hi_c++;
            if (pwm_lo) lo_c++;
            if (!pwm_hi && !pwm_lo) both0++;
            if (pwm_hi && pwm_lo) both1++;
            if (pwm_hi == pwm_lo) eq++;
        end
    endtask

    // Returns at the first sample where pwm_hi has just risen.
    task automatic wait_rise();
        logic prev;
        int guard;
        prev = pwm_hi;
        guard = 0;
        do begin
            prev = pwm_hi;
            @(negedge clk);
            guard++;
        end while (!(!prev && pwm_hi) && guard < 100);
    endtask

    task automatic t_reset();
        tick(1);
        chk(pwm_hi == 1'b0 && pwm_lo == 1'b0, "R1", "pins low in reset",
            {pwm_hi, pwm_lo}, 0);
        chk(cfg_q == 16'h00CC, "R12", "reset cfg", cfg_q, 16'h00CC);
        rst_n = 1'b1;
        tick(1);
    endtask

    task automatic t_modes();
        int h, l, b0, b1, e;
        period = 8; duty = 3;
        wr_cfg(2'b11, mk_cfg(2'b00, 2'b11, 0, 0, 1, 1, 0, 0));
        tick(20);
        window(16, h, l, b0, b1, e);
        chk(h == 6, "R1", "comp hi count", h, 6);
        chk(e == 0, "R1", "comp equal samples", e, 0);
        wr_cfg(2'b01, mk_cfg(2'b01, 2'b11, 0, 0, 1, 1, 0, 0));
        tick(3);
        window(16, h, l, b0, b1, e);
        chk(h == 6 && e == 16, "R2", "redundant hi count / equal", h * 100 + e, 616);
        wr_cfg(2'b01, mk_cfg(2'b10, 2'b11, 0, 0, 1, 1, 0, 0));
        tick(20);
        window(16, h, l, b0, b1, e);
        chk(h == 3, "R3", "push-pull hi count", h, 3);
        chk(l == 3, "R3", "push-pull lo count", l, 3);
        chk(b1 == 0, "R3", "push-pull both high", b1, 0);
    endtask

    task automatic t_clamp();
        int h, l, b0, b1, e;
        wr_cfg(2'b01, mk_cfg(2'b00, 2'b11, 0, 0, 1, 1, 0, 0));
        duty = 0;
        tick(20);
        window(16, h, l, b0, b1, e);
        chk(h == 0 && l == 16, "R4", "duty zero hi/lo", h * 100 + l, 16);
        duty = 9;
        tick(20);
        window(16, h, l, b0, b1, e);
        chk(h == 16 && l == 0, "R4", "duty above period hi/lo", h * 100 + l, 1600);
        duty = 8;
        tick(20);
        window(16, h, l, b0, b1, e);
        chk(h == 16, "R4", "duty equal period hi", h, 16);
        duty = 2;
        tick(20);
        window(16, h, l, b0, b1, e);
        chk(h == 4, "R4", "duty two hi count", h, 4);
    endtask

    task automatic t_update();
        int h, l, b0, b1, e, acc;
        // shadowed: mid-period duty change waits for the boundary
        wr_cfg(2'b01, mk_cfg(2'b00, 2'b11, 0, 0, 1, 1, 0, 0));
        duty = 3;
        tick(20);
        wait_rise();
        acc = 1;
        @(negedge clk);
        if (pwm_hi) acc++;
        duty = 6;
        window(6, h, l, b0, b1, e);
        acc += h;
        chk(acc == 3, "R5", "shadowed period keeps old duty", acc, 3);
        window(8, h, l, b0, b1, e);
        chk(h == 6, "R5", "shadowed next period new duty", h, 6);
        // immediate: change applies from the next cycle
        wr_cfg(2'b01, mk_cfg(2'b00, 2'b11, 0, 1, 1, 1, 0, 0));
        duty = 3;
        tick(20);
        wait_rise();
        acc = 1;
        @(negedge clk);
        if (pwm_hi) acc++;
        duty = 6;
        window(6, h, l, b0, b1, e);
        acc += h;
        chk(acc == 6, "R5", "immediate update same period", acc, 6);
        wr_cfg(2'b01, mk_cfg(2'b00, 2'b11, 0, 0, 1, 1, 0, 0));
    endtask

    task automatic t_cbc();
        int forced;
        period = 8; duty = 4;
        wr_cfg(2'b11, mk_cfg(2'b00, 2'b01, 0, 0, 1, 1, 0, 0));
        tick(20);
        wait_rise();
        fault_in = 1'b1;
        @(negedge clk);
        chk(!pwm_hi && !pwm_lo, "R6", "fault forces both pins", {pwm_hi, pwm_lo}, 0);
        @(negedge clk);
        fault_in = 1'b0;
        forced = 0;
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            if (!pwm_hi && !pwm_lo) forced++;
        end
        chk(forced == 5, "R8", "override held to period end", forced, 5);
        @(negedge clk);
        chk(pwm_hi && !pwm_lo, "R8", "resume at next period", {pwm_hi, pwm_lo}, 2);
    endtask

    task automatic t_levels();
        int h, l, b0, b1, e;
        wr_cfg(2'b11, mk_cfg(2'b00, 2'b01, 0, 0, 1, 1, 1, 1));
        tick(4);
        clim_in = 1'b1;
        tick(2);
        window(8, h, l, b0, b1, e);
        chk(b1 == 8, "R6", "current limit forces levels 1/1", b1, 8);
        clim_in = 1'b0;
        tick(12);
    endtask

    task automatic t_indep();
        int h, l, b0, b1, e;
        wr_cfg(2'b11, mk_cfg(2'b00, 2'b01, 1, 0, 1, 1, 0, 0));
        tick(4);
        clim_in = 1'b1;
        tick(2);
        window(8, h, l, b0, b1, e);
        chk(h == 0 && l == 4, "R7", "current limit only on high side", h * 100 + l, 4);
        clim_in = 1'b0;
        tick(12);
        fault_in = 1'b1;
        tick(2);
        window(8, h, l, b0, b1, e);
        chk(h == 4 && l == 0, "R7", "fault only on low side", h * 100 + l, 400);
        fault_in = 1'b0;
        tick(12);
    endtask

    task automatic t_latch();
        int h, l, b0, b1, e;
        wr_cfg(2'b11, mk_cfg(2'b00, 2'b00, 0, 0, 1, 1, 0, 0));
        tick(4);
        fault_in = 1'b1;
        @(negedge clk);
        fault_in = 1'b0;
        tick(20);
        window(8, h, l, b0, b1, e);
        chk(b0 == 8, "R9", "rising edge latched", b0, 8);
        pulse_clear();
        tick(2);
        window(8, h, l, b0, b1, e);
        chk(h == 4 && b0 == 0, "R10", "clear while inactive releases", h, 4);
        fault_in = 1'b1;
        tick(2);
        pulse_clear();
        fault_in = 1'b0;
        tick(3);
        window(8, h, l, b0, b1, e);
        chk(b0 == 8, "R10", "clear while active ignored", b0, 8);
        pulse_clear();
        tick(2);
        // active-low fault: rising edge is the opposite edge
        wr_cfg(2'b01, mk_cfg(2'b00, 2'b00, 0, 0, 0, 1, 0, 0));
        tick(2);
        fault_in = 1'b1;
        tick(3);
        window(8, h, l, b0, b1, e);
        chk(h == 4 && b0 == 0, "R9", "opposite rising edge ignored", h, 4);
        fault_in = 1'b0;
        tick(2);
        window(8, h, l, b0, b1, e);
        chk(b0 == 8, "R9", "falling edge latched active-low", b0, 8);
        pulse_clear();
        tick(2);
        window(8, h, l, b0, b1, e);
        chk(b0 == 8, "R10", "clear while low input active ignored", b0, 8);
        fault_in = 1'b1;
        tick(1);
        pulse_clear();
        tick(2);
        window(8, h, l, b0, b1, e);
        chk(h == 4 && b0 == 0, "R10", "clear after low input inactive", h, 4);
        // active-high again with input high: falling edge is opposite
        wr_cfg(2'b01, mk_cfg(2'b00, 2'b00, 0, 0, 1, 1, 0, 0));
        tick(2);
        fault_in = 1'b0;
        tick(3);
        window(8, h, l, b0, b1, e);
        chk(h == 4 && b0 == 0, "R9", "opposite falling edge ignored", h, 4);
    endtask

    task automatic t_off();
        int h, l, b0, b1, e;
        wr_cfg(2'b01, mk_cfg(2'b00, 2'b11, 0, 0, 1, 1, 0, 0));
        tick(2);
        fault_in = 1'b1;
        clim_in = 1'b1;
        tick(2);
        window(8, h, l, b0, b1, e);
        chk(h == 4 && l == 4, "R11", "inputs ignored when disabled", h * 100 + l, 404);
        fault_in = 1'b0;
        clim_in = 1'b0;
        tick(2);
    endtask

    task automatic t_bytes();
        wr_cfg(2'b11, 16'h1234);
        chk(cfg_q == 16'h1234, "R12", "word write", cfg_q, 16'h1234);
        wr_cfg(2'b10, 16'hABCD);
        chk(cfg_q == 16'hAB34, "R12", "upper byte write", cfg_q, 16'hAB34);
        wr_cfg(2'b01, 16'h5678);
        chk(cfg_q == 16'hAB78, "R12", "lower byte write", cfg_q, 16'hAB78);
        wr_cfg(2'b00, 16'hFFFF);
        chk(cfg_q == 16'hAB78, "R12", "no byte enabled", cfg_q, 16'hAB78);
    endtask

    initial begin
        t_reset();
        t_modes();
        t_clamp();
        t_update();
        t_cbc();
        t_levels();
        t_indep();
        t_latch();
        t_off();
        t_bytes();
        if (!finished) begin
            finished = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", WATCHDOG, 0);
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end
endmodule